// File: doc/BRIEF.md
# Flags Save/Restore Masking Unit

This block sits beside the flags register of a processor core. It handles the instructions that copy the 32-bit flags word to the stack and back. On a save request it produces the word to be written to the stack. The save is 16 bits or 32 bits wide, and some bits are hidden from the 32-bit image. On a restore request it takes the word read from the stack. It then builds a per-bit write permission from three things: the execution mode, the current privilege level (CPL) and the I/O privilege field held in the flags. Only the permitted bits are merged into the new flags value.

The address arithmetic and the memory traffic belong to the surrounding pipeline. That logic presents the current flags word, the popped word and one-cycle strobes. All results come out of registers one clock after the strobe. The block gives a write pulse for new flags, a valid pulse for push data, or a fault pulse. The current flags register is updated only from the write pulse.

The execution mode input uses this encoding: 2'b00 is real mode, 2'b01 is protected mode, 2'b10 is virtual-8086 mode, and 2'b11 is handled as protected mode. The I/O privilege field is bits 13:12 of `flags_cur`.

Top module: `flg_stack_mask`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `push_vld`, `flags_wr` and `fault` are 0. `push_data` and `flags_new` are also 0 during that time.
- R2: A 32-bit push (`op_wide`=1) that does not fault gives `push_vld`=1 one cycle after `push_req`. Its `push_data` is `flags_cur` AND 32'h00FC_FFFF, so bit 16 (RF) and bit 17 (VM) always read 0.
- R3: A 16-bit push (`op_wide`=0) that does not fault gives `push_data` = {16'h0000, `flags_cur[15:0]`}.
- R4: A push in virtual-8086 mode when the I/O privilege field is below 3 gives a one-cycle `fault` pulse and no `push_vld`.
- R5: A pop that does not fault gives `flags_wr`=1 one cycle after `pop_req`, and its `flags_new` has bit 1 set to 1. The bits in 32'h0000_4DD5 are always copied from the popped word: CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, DF=10, OF=11 and NT=14. Every bit that is not permitted keeps its `flags_cur` value.
- R6: A 32-bit pop also copies AC (bit 18) and ID (bit 21). A 16-bit pop uses only `pop_data[15:0]` and keeps bits 31:16 from `flags_cur`.
- R7: In protected mode, a pop writes IOPL (bits 13:12) only when CPL is 0. It writes IF (bit 9) only when CPL is at most IOPL.
- R8: In real mode, a pop always writes IF and IOPL.
- R9: In virtual-8086 mode, a pop with IOPL below 3 gives a `fault` pulse and no `flags_wr`. Otherwise IF is written and IOPL keeps its value.
- R10: No pop in any mode changes RF (bit 16), VM (bit 17), VIF (bit 19) or VIP (bit 20).
- R11: If `push_req` and `pop_req` are high in the same cycle, only the push is served and `flags_wr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| cpu_mode | input | 2 | 00 real, 01 protected, 10 virtual-8086, 11 as protected |
| cpl | input | 2 | Current privilege level |
| flags_cur | input | 32 | Current flags register value |
| pop_data | input | 32 | Word read from the stack |
| push_req | input | 1 | One-cycle save strobe |
| pop_req | input | 1 | One-cycle restore strobe |
| push_data | output | 32 | Word to write to the stack |
| push_vld | output | 1 | Pulse: `push_data` is valid |
| flags_new | output | 32 | Merged flags after a restore |
| flags_wr | output | 1 | Pulse: load `flags_new` into the flags register |
| fault | output | 1 | Pulse: general-protection fault on the request |

## Verification
The hardest cases depend on the relation between CPL and the I/O privilege field that the popped flags may themselves rewrite. Examples are protected mode with CPL equal to IOPL, or CPL above it, and virtual-8086 mode exactly at IOPL 2 versus 3. The stimulus reaches these by sweeping every mode code, every CPL and every IOPL with both operand sizes. It uses all-ones, all-zeros and mixed flag and popped patterns, so each mask bit is seen both when it may be written and when it may not. A case with both strobes high together covers the arbitration.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int FLAG_W = 32;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10,
    MODE_RSVD = 2'b11
  } cpu_mode_e;

  // bit positions the merge depends on
  localparam int B_FIXED1  = 1;
  localparam int B_IF      = 9;
  localparam int B_IOPL_LO = 12;
  localparam int B_IOPL_HI = 13;
  localparam int B_RF      = 16;
  localparam int B_VM      = 17;
  localparam int B_VIF     = 19;
  localparam int B_VIP     = 20;

  localparam logic [FLAG_W-1:0] MASK_ALWAYS = 32'h0000_4DD5;
  localparam logic [FLAG_W-1:0] MASK_WIDE   = 32'h0024_0000;
  localparam logic [FLAG_W-1:0] MASK_IF     = 32'h0000_0200;
  localparam logic [FLAG_W-1:0] MASK_IOPL   = 32'h0000_3000;
  localparam logic [FLAG_W-1:0] PUSH_KEEP   = 32'h00FC_FFFF;
  localparam logic [FLAG_W-1:0] VIRT_INT    = 32'h0018_0000;
  localparam int HALF_W = FLAG_W / 2;
endpackage

// File: rtl/flg_push_fmt.sv
module flg_push_fmt
  import flg_pkg::*;
(
  input  logic              wide,
  input  cpu_mode_e         mode,
  input  logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] data,
  output logic              fault
);
  logic [1:0] iopl;
  assign iopl = flags[B_IOPL_HI:B_IOPL_LO];

  always_comb begin
    fault = (mode == MODE_V86) && (iopl != 2'd3);
    if (wide) data = flags & PUSH_KEEP;
    else      data = {{(FLAG_W-HALF_W){1'b0}}, flags[HALF_W-1:0]};
  end
endmodule

// File: rtl/flg_pop_mask.sv
module flg_pop_mask
  import flg_pkg::*;
(
  input  logic              wide,
  input  cpu_mode_e         mode,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [FLAG_W-1:0] raw,
  output logic [FLAG_W-1:0] wr_mask,
  output logic [FLAG_W-1:0] src,
  output logic              fault
);
  logic [FLAG_W-1:0] sized;

  always_comb begin
    sized = wide ? raw : {{(FLAG_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
    wr_mask = MASK_ALWAYS | (wide ? MASK_WIDE : '0);
    fault   = 1'b0;
    src     = sized & ~VIRT_INT;
    unique case (mode)
      MODE_REAL: wr_mask = wr_mask | MASK_IF | MASK_IOPL;
      MODE_V86: begin
        src = sized;
        if (iopl != 2'd3) fault = 1'b1;
        else              wr_mask = wr_mask | MASK_IF;
      end
      default: begin
        if (cpl == 2'd0)  wr_mask = wr_mask | MASK_IOPL;
        if (cpl <= iopl)  wr_mask = wr_mask | MASK_IF;
      end
    endcase
  end
endmodule

// File: rtl/flg_merge.sv
module flg_merge #(
  parameter int W     = 32,
  parameter int ONE_AT = 1
) (
  input  logic [W-1:0] old_v,
  input  logic [W-1:0] src_v,
  input  logic [W-1:0] mask,
  output logic [W-1:0] new_v
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == ONE_AT) begin : g_fixed
      assign new_v[b] = 1'b1;
    end else begin : g_sel
      assign new_v[b] = mask[b] ? src_v[b] : old_v[b];
    end
  end
endmodule

// File: rtl/flg_stack_mask.sv
module flg_stack_mask
  import flg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        op_wide,
  input  logic [1:0]  cpu_mode,
  input  logic [1:0]  cpl,
  input  logic [31:0] flags_cur,
  input  logic [31:0] pop_data,
  input  logic        push_req,
  input  logic        pop_req,
  output logic [31:0] push_data,
  output logic        push_vld,
  output logic [31:0] flags_new,
  output logic        flags_wr,
  output logic        fault
);
  cpu_mode_e         mode;
  logic [FLAG_W-1:0] psh_word, pop_mask, pop_src, merged;
  logic              psh_fault, pop_fault;

  assign mode = cpu_mode_e'(cpu_mode);

  flg_push_fmt u_push (
    .wide(op_wide), .mode(mode), .flags(flags_cur),
    .data(psh_word), .fault(psh_fault)
  );

  flg_pop_mask u_mask (
    .wide(op_wide), .mode(mode), .cpl(cpl),
    .iopl(flags_cur[B_IOPL_HI:B_IOPL_LO]), .raw(pop_data),
    .wr_mask(pop_mask), .src(pop_src), .fault(pop_fault)
  );

  flg_merge #(.W(FLAG_W), .ONE_AT(B_FIXED1)) u_merge (
    .old_v(flags_cur), .src_v(pop_src), .mask(pop_mask), .new_v(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      push_data <= '0;
      push_vld  <= 1'b0;
      flags_new <= '0;
      flags_wr  <= 1'b0;
      fault     <= 1'b0;
    end else begin
      push_vld <= 1'b0;
      flags_wr <= 1'b0;
      fault    <= 1'b0;
      if (push_req) begin
        if (psh_fault) fault <= 1'b1;
        else begin
          push_vld  <= 1'b1;
          push_data <= psh_word;
        end
      end else if (pop_req) begin
        if (pop_fault) fault <= 1'b1;
        else begin
          flags_wr  <= 1'b1;
          flags_new <= merged;
        end
      end
    end
  end

  AST_PUSH_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    push_vld |-> (push_data[B_VM:B_RF] == 2'b00)); // R2
  AST_PUSH_NARROW: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !op_wide && !psh_fault) |=> (push_data[31:16] == 16'h0)); // R3
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $countones({push_vld, flags_wr, fault}) <= 1); // R4
  AST_BIT1_SET: assert property (@(posedge clk) disable iff (rst)
    flags_wr |-> flags_new[B_FIXED1]); // R5
  AST_V86_LOW_IOPL: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && mode == MODE_V86 && flags_cur[13:12] != 2'd3) |=> (fault && !flags_wr)); // R9
  AST_PROTECTED_BITS: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req) |=> (!flags_wr || (flags_new[B_VIP:B_VIF] == $past(flags_cur[B_VIP:B_VIF])
      && flags_new[B_VM:B_RF] == $past(flags_cur[B_VM:B_RF])))); // R10
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req) |=> !flags_wr); // R11
endmodule

// File: tb/flg_stack_mask_test.sv
`timescale 1ns/1ps
module flg_stack_mask_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_wide;
  logic [1:0]  cpu_mode, cpl;
  logic [31:0] flags_cur, pop_data;
  logic        push_req, pop_req;
  logic [31:0] push_data, flags_new;
  logic        push_vld, flags_wr, fault;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flg_stack_mask uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mask(input int m, input int c, input int io,
                                           input bit w, output bit flt);
    logic [31:0] mk = 32'h4DD5 | (w ? 32'h240000 : 32'h0);
    flt = 0;
    if (m == 0) mk |= 32'h3200;
    else if (m == 2) begin
      if (io < 3) flt = 1; else mk |= 32'h200;
    end else begin
      if (c == 0) mk |= 32'h3000;
      if (c <= io) mk |= 32'h200;
    end
    return mk;
  endfunction

  task automatic do_op(input bit psh, input bit pp);
    @(negedge clk);
    push_req = psh; pop_req = pp;
    @(negedge clk);
    push_req = 0; pop_req = 0;
  endtask

  initial begin
    logic [31:0] olds [4];
    logic [31:0] pops [4];
    olds[0] = 32'h0000_0000; pops[0] = 32'hFFFF_FFFF;
    olds[1] = 32'hFFFF_FFFF; pops[1] = 32'h0000_0000;
    olds[2] = 32'h5A3C_96E1; pops[2] = 32'hA5C3_691E;
    olds[3] = 32'h0013_0A82; pops[3] = 32'h00EC_F57D;
    rst = 1; op_wide = 0; cpu_mode = 0; cpl = 0; flags_cur = 0; pop_data = 0;
    push_req = 0; pop_req = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {push_vld, flags_wr, fault, push_data, flags_new[28:0]}, 64'h0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {61'h0, push_vld, flags_wr, fault}, 64'h0);

    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int io = 0; io < 4; io++)
          for (int w = 0; w < 2; w++)
            for (int p = 0; p < 4; p++) begin
              logic [31:0] old, mk, pd, exp;
              bit flt, pflt;
              old = olds[p]; old[13:12] = io[1:0];
              cpu_mode = m[1:0]; cpl = c[1:0]; op_wide = w[0];
              flags_cur = old; pop_data = pops[p];
              // push
              do_op(1, 0);
              pflt = (m == 2) && (io < 3);
              if (pflt) chk("R4 push fault", {62'h0, fault, push_vld}, 64'h2);
              else if (w == 1) chk("R2 wide push", {31'h0, push_vld, push_data}, {31'h0, 1'b1, old & 32'h00FC_FFFF});
              else chk("R3 narrow push", {31'h0, push_vld, push_data}, {31'h0, 1'b1, 16'h0, old[15:0]});
              // pop
              do_op(0, 1);
              mk = ref_mask(m, c, io, w[0], flt);
              pd = w ? pops[p] : {16'h0, pops[p][15:0]};
              if (m != 2) pd &= ~32'h0018_0000;
              exp = (old & ~mk) | (pd & mk) | 32'h2;
              if (flt) chk("R9 pop fault", {62'h0, fault, flags_wr}, 64'h2);
              else begin
                if (m == 0) chk("R8 real pop", {31'h0, flags_wr, flags_new}, {31'h0, 1'b1, exp});
                else if (m == 2) chk("R9 v86 pop", {31'h0, flags_wr, flags_new}, {31'h0, 1'b1, exp});
                else chk("R7 protected pop", {31'h0, flags_wr, flags_new}, {31'h0, 1'b1, exp});
                chk("R5 arith bits and bit1", {32'h0, flags_new & 32'h4DD7}, {32'h0, (pd & 32'h4DD5) | 32'h2});
                chk("R6 upper bits", {32'h0, flags_new & 32'hFFFF_0000},
                    {32'h0, w ? ((old & 32'hFFDB_0000) | (pd & 32'h0024_0000)) : (old & 32'hFFFF_0000)});
                chk("R10 RF VM VIF VIP kept", {32'h0, flags_new & 32'h001B_0000}, {32'h0, old & 32'h001B_0000});
              end
            end

    // both strobes together
    cpu_mode = 0; op_wide = 1; flags_cur = 32'h0000_0202; pop_data = 32'hFFFF_FFFF;
    do_op(1, 1);
    chk("R11 push served", {30'h0, push_vld, flags_wr, push_data}, {30'h0, 2'b10, 32'h0000_0202});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule